// File: doc/BRIEF.md
# Command Packet Header Assembler

This block turns command-mode transfers, written by software through a register interface, into link packets. Software places any payload for a long packet into a write-payload FIFO as 32-bit words, four bytes each with the least significant byte first. It then writes a 24-bit header word into a command FIFO. Each header that reaches the front of that FIFO is sent as a byte stream: a data identifier byte, two header bytes, a Hamming ECC byte and, for long packets, the payload followed by a 16-bit checksum.

Responses from the peripheral arrive one byte at a time on an injection port. They are packed into 32-bit words and queued in a read-payload FIFO, which software drains through the same data path. A status byte reports whether each of the three FIFOs is empty and whether a read response has completed. A sticky flag records any header write that was lost because the command FIFO was full.

Top module: `cmdpkt_assembler`

## Requirements
- R1: After reset the status byte reads 8'h2A, meaning bits 1, 3 and 5 are set and all other bits are clear. `hdr_overflow` and `tx_valid` are both low.
- R2: The header word holds the data type in bits 5:0, the virtual channel in bits 7:6, the first parameter or count low byte in bits 15:8 and the second parameter or count high byte in bits 23:16. A packet starts with bits 7:0 as one byte, followed by bits 15:8 and then bits 23:16.
- R3: A packet is long when the low nibble of its data type is 9, C, D or E. Every other type is short, and a short packet is exactly four bytes: the three header bytes and the ECC.
- R4: The fourth byte of every packet is the 6-bit Hamming ECC of the 24 header bits, placed in bits 5:0 with bits 7:6 zero. Header bit i adds its syndrome to the ECC. For bits 0 to 23 the syndromes are 07 0B 0D 0E 13 15 16 19 1A 1C 23 25 26 29 2A 2C 31 32 34 38 1F 2F 37 3B (hex).
- R5: For a long packet the word count is {bits 23:16, bits 15:8}. That many payload bytes follow the ECC, taken from the write-payload FIFO least significant byte first. The unused upper bytes of the final word are discarded.
- R6: A long packet ends with a CRC-16 over its payload bytes, low byte first. The CRC uses polynomial x^16+x^12+x^5+1, processed LSB first (0x8408), with initial value 0xFFFF and no final inversion. With a word count of zero the CRC is FF FF.
- R7: If the write-payload FIFO is empty while payload is still owed, `tx_valid` stays low until a word arrives. The stream then resumes with no byte lost or repeated.
- R8: `tx_first` marks the first byte of every packet and `tx_last` marks its final byte. At least one cycle with `tx_valid` low separates two packets.
- R9: A header write while the command FIFO holds `CMD_DEPTH` entries is dropped and never sent. It sets `hdr_overflow`, which stays set until reset. Status bit 5 reads 1 only while the command FIFO is empty.
- R10: Response bytes are packed least significant byte first into 32-bit words. A word is queued after its fourth byte or on a byte marked last, with the unused bytes zero. `rd_data` shows the oldest word, `rd_pop` removes it, and status bit 1 reads 1 while the read-payload FIFO is empty.
- R11: Status bit 7 is set by a response byte marked last and cleared by an accepted header write. When both happen in the same cycle, the bit ends set.
- R12: Status bit 3 reads 0 while the write-payload FIFO holds any word and 1 once it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pld_wr_en | input | 1 | Push a word into the write-payload FIFO |
| pld_wr_data | input | 32 | Payload word, least significant byte first |
| hdr_wr_en | input | 1 | Push a header word into the command FIFO |
| hdr_wr_data | input | 24 | Header word: type, channel, two bytes |
| rsp_valid | input | 1 | Response byte present |
| rsp_byte | input | 8 | Response byte |
| rsp_last | input | 1 | Response byte is the final one |
| rd_pop | input | 1 | Remove the oldest read-payload word |
| rd_data | output | 32 | Oldest read-payload word |
| status | output | 8 | Bit 1 read empty, bit 3 payload empty, bit 5 command empty, bit 7 read done |
| hdr_overflow | output | 1 | Sticky: a header write was dropped |
| tx_valid | output | 1 | Output byte present |
| tx_byte | output | 8 | Output byte |
| tx_first | output | 1 | First byte of a packet |
| tx_last | output | 1 | Final byte of a packet |

## Verification
The read-done flag has two causes that can land in the same cycle: a final response byte sets it, and an accepted header write clears it. The bench first clears the flag with a plain header write. It then drives a last-marked response byte and a header write on the same clock edge and expects the flag to be set afterwards. In the same run it checks that the header in that collision is still sent correctly and that the response byte lands zero-padded in the read FIFO.

// File: rtl/cmdpkt_pkg.sv
package cmdpkt_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HDR,
        S_PLD,
        S_CRC
    } ser_state_e;

    typedef struct packed {
        logic [7:0] b2;
        logic [7:0] b1;
        logic [1:0] vc;
        logic [5:0] dt;
    } hdr_word_t;

    localparam int HDR_W = 24;

    // Parity masks over the 24 header bits, index = ECC bit
    localparam logic [23:0] ECC_MASK [6] = '{
        24'hF12CB7, 24'hF2555B, 24'h749A6D,
        24'hB8E38E, 24'hDF03F0, 24'hEFFC00
    };

    function automatic logic is_long(input logic [5:0] dt);
        case (dt[3:0])
            4'h9, 4'hC, 4'hD, 4'hE: is_long = 1'b1;
            default:                is_long = 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] hdr_ecc(input logic [23:0] d);
        logic [7:0] e;
        e = '0;
        for (int i = 0; i < 6; i++) begin
            e[i] = ^(d & ECC_MASK[i]);
        end
        return e;
    endfunction

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/cmdpkt_fifo.sv
module cmdpkt_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R10
    fifo_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/cmdpkt_rsp_pack.sv
module cmdpkt_rsp_pack (
    input  logic        clk,
    input  logic        rst,
    input  logic        rsp_valid,
    input  logic [7:0]  rsp_byte,
    input  logic        rsp_last,
    output logic        word_push,
    output logic [31:0] word
);
    logic [23:0] acc;
    logic [1:0]  bcnt;

    always_comb begin
        word = {8'h00, acc};
        word[{bcnt, 3'b000} +: 8] = rsp_byte;
    end

    assign word_push = rsp_valid && (bcnt == 2'd3 || rsp_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            bcnt <= '0;
        end else if (rsp_valid) begin
            if (word_push) begin
                acc  <= '0;
                bcnt <= '0;
            end else begin
                acc  <= word[23:0];
                bcnt <= bcnt + 1'b1;
            end
        end
    end

    // R10
    rsp_last_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_last) |=> (bcnt == 2'd0));

endmodule

// File: rtl/cmdpkt_serializer.sv
module cmdpkt_serializer
    import cmdpkt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_empty,
    input  hdr_word_t   cmd_head,
    output logic        cmd_pop,
    input  logic        pld_empty,
    input  logic [31:0] pld_head,
    output logic        pld_pop,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        tx_first,
    output logic        tx_last
);
    ser_state_e state;
    hdr_word_t  hdr;
    logic [7:0] ecc;
    logic       long_q;
    logic [1:0] idx;
    logic [1:0] bsel;
    logic [15:0] remain;
    logic [15:0] crc;

    always_comb begin
        tx_valid = 1'b0;
        tx_byte  = 8'h00;
        tx_first = 1'b0;
        tx_last  = 1'b0;
        cmd_pop  = 1'b0;
        pld_pop  = 1'b0;
        case (state)
            S_IDLE: cmd_pop = !cmd_empty;
            S_HDR: begin
                tx_valid = 1'b1;
                tx_first = (idx == 2'd0);
                tx_last  = (idx == 2'd3) && !long_q;
                case (idx)
                    2'd0:    tx_byte = {hdr.vc, hdr.dt};
                    2'd1:    tx_byte = hdr.b1;
                    2'd2:    tx_byte = hdr.b2;
                    default: tx_byte = ecc;
                endcase
            end
            S_PLD: begin
                tx_valid = !pld_empty;
                tx_byte  = pld_head[{bsel, 3'b000} +: 8];
                pld_pop  = !pld_empty && (bsel == 2'd3 || remain == 16'd1);
            end
            default: begin
                tx_valid = 1'b1;
                tx_byte  = (idx == 2'd0) ? crc[7:0] : crc[15:8];
                tx_last  = (idx == 2'd1);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            hdr    <= '0;
            ecc    <= '0;
            long_q <= 1'b0;
            idx    <= '0;
            bsel   <= '0;
            remain <= '0;
            crc    <= 16'hFFFF;
        end else begin
            case (state)
                S_IDLE: begin
                    if (!cmd_empty) begin
                        hdr    <= cmd_head;
                        ecc    <= hdr_ecc(cmd_head);
                        long_q <= is_long(cmd_head.dt);
                        remain <= {cmd_head.b2, cmd_head.b1};
                        idx    <= '0;
                        bsel   <= '0;
                        crc    <= 16'hFFFF;
                        state  <= S_HDR;
                    end
                end
                S_HDR: begin
                    if (idx == 2'd3) begin
                        idx <= '0;
                        if (!long_q)            state <= S_IDLE;
                        else if (remain == '0)  state <= S_CRC;
                        else                    state <= S_PLD;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_PLD: begin
                    if (!pld_empty) begin
                        crc    <= crc16_step(crc, tx_byte);
                        remain <= remain - 1'b1;
                        bsel   <= bsel + 1'b1;
                        if (remain == 16'd1) state <= S_CRC;
                    end
                end
                default: begin
                    if (idx == 2'd1) begin
                        idx   <= '0;
                        state <= S_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

    // R8
    pkt_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_last) |=> !tx_valid);

    // R7
    pld_pop_guard_chk: assert property (@(posedge clk) disable iff (rst)
        pld_pop |-> (!pld_empty && tx_valid));

    // R8
    first_valid_chk: assert property (@(posedge clk) disable iff (rst)
        tx_first |-> (tx_valid && !tx_last));

endmodule

// File: rtl/cmdpkt_assembler.sv
module cmdpkt_assembler
    import cmdpkt_pkg::*;
#(
    parameter int CMD_DEPTH = 4,
    parameter int PLD_DEPTH = 8,
    parameter int RD_DEPTH  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pld_wr_en,
    input  logic [31:0] pld_wr_data,
    input  logic        hdr_wr_en,
    input  logic [23:0] hdr_wr_data,
    input  logic        rsp_valid,
    input  logic [7:0]  rsp_byte,
    input  logic        rsp_last,
    input  logic        rd_pop,
    output logic [31:0] rd_data,
    output logic [7:0]  status,
    output logic        hdr_overflow,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        tx_first,
    output logic        tx_last
);
    logic            cmd_empty, cmd_full, cmd_pop;
    logic [HDR_W-1:0] cmd_dout;
    logic            pld_empty, pld_full, pld_pop;
    logic [31:0]     pld_dout;
    logic            rd_empty, rd_full, rd_push;
    logic [31:0]     rd_word;
    logic            rd_done;
    logic            hdr_accept;

    assign hdr_accept = hdr_wr_en && !cmd_full;

    cmdpkt_fifo #(.WIDTH(HDR_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
        .clk(clk), .rst(rst), .push(hdr_wr_en), .din(hdr_wr_data),
        .pop(cmd_pop), .dout(cmd_dout), .empty(cmd_empty), .full(cmd_full)
    );

    cmdpkt_fifo #(.WIDTH(32), .DEPTH(PLD_DEPTH)) u_pld_fifo (
        .clk(clk), .rst(rst), .push(pld_wr_en), .din(pld_wr_data),
        .pop(pld_pop), .dout(pld_dout), .empty(pld_empty), .full(pld_full)
    );

    cmdpkt_fifo #(.WIDTH(32), .DEPTH(RD_DEPTH)) u_rd_fifo (
        .clk(clk), .rst(rst), .push(rd_push), .din(rd_word),
        .pop(rd_pop), .dout(rd_data), .empty(rd_empty), .full(rd_full)
    );

    cmdpkt_rsp_pack u_rsp_pack (
        .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
        .rsp_last(rsp_last), .word_push(rd_push), .word(rd_word)
    );

    cmdpkt_serializer u_ser (
        .clk(clk), .rst(rst),
        .cmd_empty(cmd_empty), .cmd_head(hdr_word_t'(cmd_dout)), .cmd_pop(cmd_pop),
        .pld_empty(pld_empty), .pld_head(pld_dout), .pld_pop(pld_pop),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_first(tx_first), .tx_last(tx_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_overflow <= 1'b0;
            rd_done      <= 1'b0;
        end else begin
            if (hdr_wr_en && cmd_full) hdr_overflow <= 1'b1;
            if (rsp_valid && rsp_last) rd_done <= 1'b1;
            else if (hdr_accept)       rd_done <= 1'b0;
        end
    end

    assign status = {rd_done, 1'b0, cmd_empty, 1'b0, pld_empty, 1'b0, rd_empty, 1'b0};

    // R9
    overflow_set_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_wr_en && cmd_full) |=> hdr_overflow);

    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_overflow |=> hdr_overflow);

    // R11
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_last) |=> status[7]);

    // R12
    pld_full_chk: assert property (@(posedge clk) disable iff (rst)
        pld_full |-> !status[3]);

    // R10
    rd_full_chk: assert property (@(posedge clk) disable iff (rst)
        rd_full |-> !status[1]);

endmodule

// File: tb/cmdpkt_assembler_tb.sv
module cmdpkt_assembler_tb;
    typedef logic [7:0] bq_t[$];

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pld_wr_en = 1'b0;
    logic [31:0] pld_wr_data = '0;
    logic        hdr_wr_en = 1'b0;
    logic [23:0] hdr_wr_data = '0;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_byte = '0;
    logic        rsp_last = 1'b0;
    logic        rd_pop = 1'b0;
    logic [31:0] rd_data;
    logic [7:0]  status;
    logic        hdr_overflow;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_first;
    logic        tx_last;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cmdpkt_assembler u_dut (
        .clk(clk), .rst(rst), .pld_wr_en(pld_wr_en), .pld_wr_data(pld_wr_data),
        .hdr_wr_en(hdr_wr_en), .hdr_wr_data(hdr_wr_data), .rsp_valid(rsp_valid),
        .rsp_byte(rsp_byte), .rsp_last(rsp_last), .rd_pop(rd_pop), .rd_data(rd_data),
        .status(status), .hdr_overflow(hdr_overflow), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_first(tx_first), .tx_last(tx_last)
    );

    localparam logic [5:0] SYN [24] = '{
        6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
        6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
        6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B
    };

    logic [7:0] cap_b[$];
    bit         cap_f[$];
    bit         cap_l[$];
    logic [7:0] exp_b[$];
    bit         exp_f[$];
    bit         exp_l[$];
    int         n_last = 0;
    bit         prev_last = 1'b0;
    bit         gap_bad = 1'b0;

    always @(negedge clk) begin
        if (!rst && tx_valid) begin
            cap_b.push_back(tx_byte);
            cap_f.push_back(tx_first);
            cap_l.push_back(tx_last);
            if (tx_last) n_last++;
            if (tx_first && prev_last) gap_bad = 1'b1;
        end
        prev_last = !rst && tx_valid && tx_last;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ecc_ref(input logic [23:0] h);
        logic [5:0] e = '0;
        for (int i = 0; i < 24; i++) if (h[i]) e ^= SYN[i];
        return {2'b00, e};
    endfunction

    function automatic logic [15:0] crc_ref(input bq_t d);
        logic [15:0] c = 16'hFFFF;
        foreach (d[k]) begin
            for (int i = 0; i < 8; i++) begin
                if (c[0] ^ d[k][i]) c = (c >> 1) ^ 16'h8408;
                else                c = c >> 1;
            end
        end
        return c;
    endfunction

    task automatic add_pkt(input logic [23:0] h, input bq_t pl);
        logic [15:0] wc = h[23:8];
        logic [15:0] c;
        bit lng = h[3:0] inside {4'h9, 4'hC, 4'hD, 4'hE};
        bq_t b;
        b.push_back(h[7:0]);
        b.push_back(h[15:8]);
        b.push_back(h[23:16]);
        b.push_back(ecc_ref(h));
        if (lng) begin
            for (int i = 0; i < int'(wc); i++) b.push_back(pl[i]);
            c = crc_ref(pl);
            b.push_back(c[7:0]);
            b.push_back(c[15:8]);
        end
        foreach (b[i]) begin
            exp_b.push_back(b[i]);
            exp_f.push_back(i == 0);
            exp_l.push_back(i == b.size() - 1);
        end
    endtask

    task automatic clear_cap();
        cap_b.delete(); cap_f.delete(); cap_l.delete();
        exp_b.delete(); exp_f.delete(); exp_l.delete();
        n_last = 0;
    endtask

    task automatic cmp_stream(input string req);
        int bad = -1;
        chk(req, "stream length", cap_b.size(), exp_b.size());
        if (cap_b.size() == exp_b.size()) begin
            foreach (exp_b[i]) begin
                if (bad < 0 && (cap_b[i] !== exp_b[i] || cap_f[i] != exp_f[i] || cap_l[i] != exp_l[i]))
                    bad = i;
            end
            if (bad >= 0)
                chk(req, $sformatf("byte/flags at %0d", bad),
                    {cap_f[bad], cap_l[bad], cap_b[bad]}, {exp_f[bad], exp_l[bad], exp_b[bad]});
            else
                chk(req, "stream content", 0, 0);
        end
    endtask

    task automatic wr_hdr(input logic [23:0] h);
        @(posedge clk); #1;
        hdr_wr_en = 1'b1; hdr_wr_data = h;
        @(posedge clk); #1;
        hdr_wr_en = 1'b0;
    endtask

    task automatic wr_pld(input bq_t d);
        int n = (d.size() + 3) / 4;
        for (int w = 0; w < n; w++) begin
            logic [31:0] word = 32'hEEEEEEEE;
            for (int k = 0; k < 4; k++)
                if (w * 4 + k < d.size()) word[k*8 +: 8] = d[w*4 + k];
            @(posedge clk); #1;
            pld_wr_en = 1'b1; pld_wr_data = word;
        end
        @(posedge clk); #1;
        pld_wr_en = 1'b0;
    endtask

    task automatic wait_pkts(input int n);
        int t = 0;
        while (n_last < n && t < 2000) begin
            @(posedge clk);
            t++;
        end
        repeat (3) @(posedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "status", status, 8'h2A);
        chk("R1", "overflow", hdr_overflow, 1'b0);
        chk("R1", "tx_valid", tx_valid, 1'b0);
    endtask

    task automatic t_short();
        bq_t none;
        clear_cap();
        add_pkt(24'h003C45, none);
        add_pkt(24'hA75195, none);
        wr_hdr(24'h003C45);
        wait_pkts(1);
        wr_hdr(24'hA75195);
        wait_pkts(2);
        cmp_stream("R2 R3 R4 R8 short packets");
    endtask

    task automatic t_long();
        bq_t pl = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        bq_t pl2 = '{8'hA0, 8'h0B, 8'hC4};
        clear_cap();
        wr_pld(pl);
        @(negedge clk);
        chk("R12", "payload not empty", status[3], 1'b0);
        add_pkt(24'h000639, pl);
        wr_hdr(24'h000639);
        wait_pkts(1);
        chk("R12", "payload empty after send", status[3], 1'b1);
        wr_pld(pl2);
        add_pkt(24'h0003A9, pl2);
        wr_hdr(24'h0003A9);
        wait_pkts(2);
        cmp_stream("R5 R6 long packets");
    endtask

    task automatic t_zero_len();
        bq_t none;
        clear_cap();
        add_pkt(24'h000029, none);
        wr_hdr(24'h000029);
        wait_pkts(1);
        cmp_stream("R6 zero-length CRC FFFF");
    endtask

    task automatic t_stall();
        bq_t pl = '{8'h5A, 8'hC3, 8'h01, 8'hFE};
        clear_cap();
        add_pkt(24'h00046E, pl);
        wr_hdr(24'h00046E);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R7", "bytes before payload", cap_b.size(), 4);
        chk("R7", "tx_valid while starved", tx_valid, 1'b0);
        wr_pld(pl);
        wait_pkts(1);
        cmp_stream("R7 stalled long packet");
    endtask

    task automatic t_overflow();
        bq_t pl = '{8'h10, 8'h20, 8'h30, 8'h40};
        bq_t none;
        clear_cap();
        add_pkt(24'h000439, pl);
        wr_hdr(24'h000439);
        repeat (10) @(posedge clk);
        add_pkt(24'h020105, none); wr_hdr(24'h020105);
        add_pkt(24'h040315, none); wr_hdr(24'h040315);
        add_pkt(24'h060523, none); wr_hdr(24'h060523);
        add_pkt(24'h080737, none); wr_hdr(24'h080737);
        @(negedge clk);
        chk("R9", "overflow before full write", hdr_overflow, 1'b0);
        wr_hdr(24'hFFEE03);
        @(negedge clk);
        chk("R9", "overflow set", hdr_overflow, 1'b1);
        chk("R9", "command not empty", status[5], 1'b0);
        wr_pld(pl);
        wait_pkts(5);
        repeat (10) @(posedge clk);
        cmp_stream("R9 dropped header absent");
        chk("R8", "gap between packets", gap_bad, 1'b0);
        chk("R9", "command empty after drain", status[5], 1'b1);
        chk("R9", "overflow sticky", hdr_overflow, 1'b1);
    endtask

    task automatic rsp_send(input bq_t d);
        foreach (d[i]) begin
            @(posedge clk); #1;
            rsp_valid = 1'b1; rsp_byte = d[i]; rsp_last = (i == d.size() - 1);
        end
        @(posedge clk); #1;
        rsp_valid = 1'b0; rsp_last = 1'b0;
    endtask

    task automatic pop_rd();
        @(posedge clk); #1;
        rd_pop = 1'b1;
        @(posedge clk); #1;
        rd_pop = 1'b0;
    endtask

    task automatic t_read();
        bq_t d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        @(negedge clk);
        chk("R11", "done clear before response", status[7], 1'b0);
        rsp_send(d);
        @(negedge clk);
        chk("R10", "read not empty", status[1], 1'b0);
        chk("R11", "done set", status[7], 1'b1);
        chk("R10", "first word", rd_data, 32'h44332211);
        pop_rd();
        @(negedge clk);
        chk("R10", "partial word zero padded", rd_data, 32'h00006655);
        pop_rd();
        @(negedge clk);
        chk("R10", "read empty after pops", status[1], 1'b1);
    endtask

    task automatic t_collide();
        bq_t none;
        clear_cap();
        add_pkt(24'h123405, none);
        wr_hdr(24'h123405);
        @(negedge clk);
        chk("R11", "done cleared by header", status[7], 1'b0);
        wait_pkts(1);
        add_pkt(24'h9A7815, none);
        @(posedge clk); #1;
        rsp_valid = 1'b1; rsp_byte = 8'h77; rsp_last = 1'b1;
        hdr_wr_en = 1'b1; hdr_wr_data = 24'h9A7815;
        @(posedge clk); #1;
        rsp_valid = 1'b0; rsp_last = 1'b0; hdr_wr_en = 1'b0;
        @(negedge clk);
        chk("R11", "set wins over clear", status[7], 1'b1);
        chk("R10", "single byte word", rd_data, 32'h00000077);
        wait_pkts(2);
        cmp_stream("R11 header during response end");
        pop_rd();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_short();
        t_long();
        t_zero_len();
        t_stall();
        t_overflow();
        t_read();
        t_collide();
        repeat (5) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule